// File: doc/BRIEF.md
# Receive Page Completion Controller

This block steers a stream of received packet bytes into two alternating memory pages, numbered 0 and 1, belonging to one packet channel. For every byte it accepts it supplies the page index and the byte offset at which to store the byte. It decides when the active page is complete and then hands over to the other page. Each page has its own depth, programmed as its byte count minus one. Each page also has a ready flag, which the block reads but never clears.

Two modes are supported.

- **Single-packet mode:** a page holds at most one packet. A packet longer than the page carries on at offset 0 of the next page.
- **Multi-packet mode:** a page holds several packets. A page also completes early when a packet ends one byte short of the page's last slot, because that slot could not hold a new packet's length header.

A per-page start flag tells software whether a packet begins in that page. When the next page is not ready, the block applies backpressure to the stream instead of dropping bytes.

Top module: `rx_page_done_ctl`

## Requirements
- R1: After reset the block has no page open: `in_ready`=0, `switch_req`=1, `done_pulse`=0, `pkt_start`=0 and `wr_page`=0.
- R2: A closed page opens one cycle after its `pg_ready` bit is seen high. Its first byte goes to offset 0, and each further accepted byte (`in_valid` and `in_ready` both high at a clock edge) goes to the previous offset plus 1. `wr_en` and `wr_data` mirror the accepted byte.
- R3: With `multi_mode`=0, the page completes on the byte that carries `in_last`=1, or on the byte written at offset equal to the page depth, whichever comes first.
- R4: With `multi_mode`=0, a packet cut off by a full page continues at offset 0 of the other page.
- R5: With `multi_mode`=1, the page completes on the byte at offset equal to the depth, or on an `in_last` byte at offset equal to depth-1 (when depth > 0). An `in_last` byte at any other offset does not complete the page.
- R6: With `multi_mode`=0, `pkt_start[p]` is cleared when page p opens. Its first byte then sets it to 1 if a packet begins there, or to 0 if it continues a packet from the other page.
- R7: With `multi_mode`=1, `pkt_start[p]` stays 0 for the whole time page p is open.
- R8: While the page to be opened is not ready, `in_ready`=0 and `switch_req`=1. No byte is lost: the next accepted byte lands at offset 0 of that page.
- R9: Pages are used in the order 0, 1, 0, 1, and so on. After a page completes, `wr_page` shows the other page.
- R10: A completed page produces `done_pulse`=1 for exactly one cycle, the cycle after its final byte. `done_page` in that cycle gives the completed page index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Received byte is present |
| in_data | input | DATA_W | Received byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Byte is accepted at this clock edge |
| multi_mode | input | 1 | 0 = single-packet pages, 1 = multi-packet pages |
| depth0 | input | DEPTH_W | Page 0 byte count minus one |
| depth1 | input | DEPTH_W | Page 1 byte count minus one |
| pg_ready | input | 2 | Per-page ready flag from software |
| wr_en | output | 1 | Write strobe to page memory |
| wr_page | output | 1 | Page index being written |
| wr_offset | output | DEPTH_W | Byte offset inside the page |
| wr_data | output | DATA_W | Byte to write |
| done_pulse | output | 1 | One-cycle page completion pulse |
| done_page | output | 1 | Index of the completed page |
| pkt_start | output | 2 | Per-page packet-start status |
| switch_req | output | 1 | Waiting for the next page to become ready |

## Verification
The bench uses the default parameters, DEPTH_W=12 and DATA_W=8. It programs small page depths (0, 1, 3, 7, 9 and 13) so that full pages, early completion one byte short of the end, and pages split across packets all occur within a few thousand cycles. Depth 0 makes every byte complete its own page. Phases with random ready flags hold the stream in backpressure at page switches. Phases with rare packet ends force packets to span several pages.

// File: rtl/rxpg_pkg.sv
package rxpg_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MULTI  = 1'b1
  } pg_mode_e;

  localparam int unsigned NUM_PAGES = 2;

endpackage

// File: rtl/rxpg_rst_sync.sv
module rxpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxpg_done_eval.sv
module rxpg_done_eval import rxpg_pkg::*; #(
  parameter int DEPTH_W = 12
) (
  input  logic [DEPTH_W-1:0] offset,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               last,
  input  pg_mode_e           mode,
  output logic               page_end
);

  localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

  logic full;
  logic short_end;

  always_comb begin
    full      = (offset == depth);
    // one slot left: too small for a new packet's length header
    short_end = (depth != '0) && (offset == (depth - ONE));
    unique case (mode)
      MODE_SINGLE: page_end = full | last;
      MODE_MULTI:  page_end = full | (last & short_end);
      default:     page_end = full;
    endcase
  end

endmodule

// File: rtl/rxpg_page_seq.sv
module rxpg_page_seq #(
  parameter int DEPTH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_cur,
  input  logic               accept,
  input  logic               page_end,
  output logic               cur_page,
  output logic               page_open,
  output logic               open_evt,
  output logic [DEPTH_W-1:0] offset,
  output logic               done_pulse,
  output logic               done_page
);

  localparam logic [DEPTH_W-1:0] STEP = DEPTH_W'(1);

  logic               page_n, open_n, dp_n, dpg_n;
  logic [DEPTH_W-1:0] off_n;
  logic               state_en;

  assign open_evt = !page_open && ready_cur;
  assign state_en = open_evt || accept || done_pulse;

  always_comb begin
    page_n = cur_page;
    open_n = page_open;
    off_n  = offset;
    dp_n   = 1'b0;
    dpg_n  = done_page;
    if (open_evt) begin
      open_n = 1'b1;
      off_n  = '0;
    end else if (accept) begin
      if (page_end) begin
        dp_n   = 1'b1;
        dpg_n  = cur_page;
        page_n = ~cur_page;
        open_n = 1'b0;
      end else begin
        off_n = offset + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_page   <= 1'b0;
      page_open  <= 1'b0;
      offset     <= '0;
      done_pulse <= 1'b0;
      done_page  <= 1'b0;
    end else if (state_en) begin
      cur_page   <= page_n;
      page_open  <= open_n;
      offset     <= off_n;
      done_pulse <= dp_n;
      done_page  <= dpg_n;
    end
  end

  p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  p_done_flips_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (cur_page != done_page) && !page_open);

  p_open_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_open) |-> (offset == '0));

  p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !page_end) |=> (offset == $past(offset) + STEP) && page_open);

endmodule

// File: rtl/rxpg_start_flags.sv
module rxpg_start_flags import rxpg_pkg::*; #(
  parameter int DEPTH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_evt,
  input  logic               cur_page,
  input  logic               accept,
  input  logic [DEPTH_W-1:0] offset,
  input  pg_mode_e           mode,
  input  logic               last,
  output logic [1:0]         flags
);

  logic [1:0] flags_n;
  logic       mid_q, mid_n;
  logic       flag_en;

  assign flag_en = open_evt || accept;

  always_comb begin
    flags_n = flags;
    mid_n   = mid_q;
    if (open_evt) flags_n[cur_page] = 1'b0;
    if (accept) begin
      mid_n = !last;
      if ((offset == '0) && (mode == MODE_SINGLE)) flags_n[cur_page] = !mid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mid_q <= 1'b0;
    end else if (flag_en) begin
      flags <= flags_n;
      mid_q <= mid_n;
    end
  end

  p_multi_clear_pg0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (mode == MODE_MULTI) && (offset == '0) && !cur_page) |=> !flags[0]);

  p_multi_clear_pg1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (mode == MODE_MULTI) && (offset == '0) && cur_page) |=> !flags[1]);

  p_open_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_evt && !accept) |=> !flags[$past(cur_page)]);

endmodule

// File: rtl/rx_page_done_ctl.sv
module rx_page_done_ctl import rxpg_pkg::*; #(
  parameter int DEPTH_W = 12,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_last,
  output logic               in_ready,
  input  logic               multi_mode,
  input  logic [DEPTH_W-1:0] depth0,
  input  logic [DEPTH_W-1:0] depth1,
  input  logic [1:0]         pg_ready,
  output logic               wr_en,
  output logic               wr_page,
  output logic [DEPTH_W-1:0] wr_offset,
  output logic [DATA_W-1:0]  wr_data,
  output logic               done_pulse,
  output logic               done_page,
  output logic [1:0]         pkt_start,
  output logic               switch_req
);

  logic               srst_n;
  logic               cur_page, page_open, open_evt, accept, page_end;
  logic [DEPTH_W-1:0] offset, cur_depth;
  pg_mode_e           mode;

  rxpg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign mode      = multi_mode ? MODE_MULTI : MODE_SINGLE;
  assign cur_depth = cur_page ? depth1 : depth0;
  assign accept    = in_valid && page_open;

  rxpg_done_eval #(.DEPTH_W(DEPTH_W)) u_eval (
    .offset   (offset),
    .depth    (cur_depth),
    .last     (in_last),
    .mode     (mode),
    .page_end (page_end)
  );

  rxpg_page_seq #(.DEPTH_W(DEPTH_W)) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .ready_cur  (pg_ready[cur_page]),
    .accept     (accept),
    .page_end   (page_end),
    .cur_page   (cur_page),
    .page_open  (page_open),
    .open_evt   (open_evt),
    .offset     (offset),
    .done_pulse (done_pulse),
    .done_page  (done_page)
  );

  rxpg_start_flags #(.DEPTH_W(DEPTH_W)) u_flags (
    .clk      (clk),
    .rst_n    (srst_n),
    .open_evt (open_evt),
    .cur_page (cur_page),
    .accept   (accept),
    .offset   (offset),
    .mode     (mode),
    .last     (in_last),
    .flags    (pkt_start)
  );

  assign in_ready   = page_open;
  assign switch_req = !page_open;
  assign wr_en      = accept;
  assign wr_page    = cur_page;
  assign wr_offset  = offset;
  assign wr_data    = in_data;

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (switch_req && !pg_ready[cur_page]) |=> $stable(cur_page) && !wr_en);

endmodule

// File: tb/rx_page_done_ctl_test.sv
module rx_page_done_ctl_test;

  localparam int CLK_P   = 10;
  localparam int DEPTH_W = 12;
  localparam int DATA_W  = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, in_last, multi_mode;
  logic [DATA_W-1:0]  in_data;
  logic [DEPTH_W-1:0] depth0, depth1;
  logic [1:0]         pg_ready;
  logic               in_ready, wr_en, wr_page, done_pulse, done_page, switch_req;
  logic [DEPTH_W-1:0] wr_offset;
  logic [DATA_W-1:0]  wr_data;
  logic [1:0]         pkt_start;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int seg_cnt = 0, short_cnt = 0, stall_cnt = 0;

  // bench model state
  bit               m_page, m_open, m_mid, e_done, e_dpage;
  bit [1:0]         m_flag;
  logic [DEPTH_W-1:0] m_off;

  always #(CLK_P/2) clk = ~clk;

  rx_page_done_ctl #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .multi_mode(multi_mode),
    .depth0(depth0), .depth1(depth1), .pg_ready(pg_ready), .wr_en(wr_en),
    .wr_page(wr_page), .wr_offset(wr_offset), .wr_data(wr_data),
    .done_pulse(done_pulse), .done_page(done_page), .pkt_start(pkt_start),
    .switch_req(switch_req)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit page_done_fn(logic [DEPTH_W-1:0] off, logic [DEPTH_W-1:0] dep,
                                      bit last, bit multi);
    bit full  = (off == dep);
    bit shrt  = (dep != 0) && (off == dep - DEPTH_W'(1));
    if (multi) return full || (last && shrt);
    return full || last;
  endfunction

  task automatic run_phase(int n, bit mm, logic [DEPTH_W-1:0] d0, logic [DEPTH_W-1:0] d1,
                           int lastmod, bit stall, bit force_short);
    for (int i = 0; i < n; i++) begin
      logic [DEPTH_W-1:0] dep;
      bit acc, fin;
      @(negedge clk);
      // compare outputs with model state of this cycle
      chk(in_ready == m_open, "R8", "in_ready", in_ready, m_open);
      chk(switch_req == !m_open, "R8", "switch_req", switch_req, !m_open);
      chk(done_pulse == e_done, "R10", "done_pulse", done_pulse, e_done);
      if (e_done) chk(done_page == e_dpage, "R10", "done_page", done_page, e_dpage);
      chk(wr_page == m_page, "R9", "wr_page", wr_page, m_page);
      if (m_open) chk(wr_offset == m_off, "R2", "wr_offset", wr_offset, m_off);
      chk(pkt_start == m_flag, mm ? "R7" : "R6", "pkt_start", pkt_start, m_flag);
      // drive inputs
      multi_mode = mm;
      depth0 = d0;
      depth1 = d1;
      pg_ready = stall ? 2'(($urandom % 3 == 0) ? 2'b11 : 2'($urandom % 2)) : 2'b11;
      in_valid = ($urandom % 4) != 0;
      in_last  = ($urandom % lastmod) == 0;
      in_data  = 8'($urandom);
      dep = m_page ? d1 : d0;
      if (force_short && mm && (dep != 0) && (m_off == dep - DEPTH_W'(1)) && ($urandom % 2 == 0))
        in_last = 1'b1;
      #1;
      chk(wr_en == (in_valid && m_open), "R2", "wr_en", wr_en, in_valid && m_open);
      if (wr_en) chk(wr_data == in_data, "R2", "wr_data", wr_data, in_data);
      // advance model to next cycle
      e_done = 1'b0;
      acc = in_valid && m_open;
      if (!m_open) begin
        if (!pg_ready[m_page]) stall_cnt++;
        else begin
          m_open = 1'b1;
          m_off = '0;
          m_flag[m_page] = 1'b0;
        end
      end else if (acc) begin
        if (m_off == 0 && !mm) begin
          m_flag[m_page] = !m_mid;
          if (m_mid) seg_cnt++;
        end
        fin = page_done_fn(m_off, dep, in_last, mm);
        if (mm && in_last && fin && m_off != dep) short_cnt++;
        m_mid = !in_last;
        if (fin) begin
          e_done = 1'b1;
          e_dpage = m_page;
          m_page = !m_page;
          m_open = 1'b0;
        end else m_off = m_off + DEPTH_W'(1);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    multi_mode = 1'b0; depth0 = 12'd7; depth1 = 12'd7; pg_ready = 2'b00;
    m_page = 0; m_open = 0; m_mid = 0; e_done = 0; e_dpage = 0; m_flag = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
    chk(switch_req == 1'b1, "R1", "switch_req", switch_req, 1);
    chk(done_pulse == 1'b0, "R1", "done_pulse", done_pulse, 0);
    chk(pkt_start == 2'b00, "R1", "pkt_start", pkt_start, 0);
    chk(wr_page == 1'b0, "R1", "wr_page", wr_page, 0);
    // R3 single mode, short packets
    run_phase(2000, 1'b0, 12'd7, 12'd7, 6, 1'b0, 1'b0);
    // R4 single mode, long packets spanning pages
    run_phase(2000, 1'b0, 12'd3, 12'd9, 14, 1'b0, 1'b0);
    // R5 multi mode, with packets ending one short of the end
    run_phase(3000, 1'b1, 12'd9, 12'd13, 4, 1'b0, 1'b1);
    // R8 stalls in both modes
    run_phase(2000, 1'b1, 12'd7, 12'd3, 5, 1'b1, 1'b1);
    run_phase(2000, 1'b0, 12'd3, 12'd7, 5, 1'b1, 1'b0);
    // tiny pages: depth 0 and 1
    run_phase(1000, 1'b0, 12'd0, 12'd1, 3, 1'b0, 1'b0);
    run_phase(1000, 1'b1, 12'd0, 12'd1, 3, 1'b0, 1'b1);
    chk(seg_cnt > 0, "R4", "continuation pages seen", seg_cnt, 1);
    chk(short_cnt > 0, "R5", "early multi completions seen", short_cnt, 1);
    chk(stall_cnt > 0, "R8", "stall cycles seen", stall_cnt, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule